// File: doc/BRIEF.md
# Stream-Addressed Configuration Register Bank

This block holds sixteen configuration words that are reached only through a shared command stream, not through an address/data register bus. Each input word carries a flag saying whether it is a command or data. A command picks what the data words after it mean: set the register pointer, write registers at the pointer, or ask for a counted burst of register reads. Data words after a write command land at the pointer, and the pointer advances after each one. So a single write command followed by sixteen data words loads the whole bank.

A read request takes one data word giving how many registers to send, starting at the pointer. The words leave one per cycle on a valid-qualified output that feeds an output FIFO. While a burst runs, the bank ignores the input stream. The register contents also drive the block's outputs: pin output enables, open-drain selects, pull-up enable, analyzer control with two self-clearing strobes, memory chip selects, an ADC calibration request and four peripheral configuration words. Other logic decodes these outputs.

Top module: `cfgb_bank`

## Requirements
- R1: After reset every register is zero, `rd_valid` is low and the pointer is 0, so a write made without first setting the pointer goes to register 0.
- R2: A word with `in_is_cmd` = 1 is a command, with its opcode in bits 7:0: 0x0B sets the pointer, 0x0C writes, 0x0D reads. After any other opcode, data words change no register and produce no read words.
- R3: In set-pointer mode, each data word loads the pointer from its bits 3:0, and the upper bits are ignored.
- R4: In write mode, each data word is stored at the pointer, and the pointer then advances by one, wrapping from 15 to 0. The new value is on the outputs in the cycle after the clock edge that samples the word.
- R5: In read mode, a data word's bits 4:0 give a count N. The bank then sends registers pointer, pointer+1, … (wrapping 15 to 0), one per cycle on `rd_valid`/`rd_word`. The first word is valid after the second clock edge after the count word is sampled. Afterwards the pointer is the old pointer + N modulo 16, and later data words start new counted reads.
- R6: A read count of 0 sends no word and leaves the pointer unchanged.
- R7: Input words that arrive while a read burst is still sending are ignored: they write nothing, change no mode and queue nothing.
- R8: Register 3 bit 3 (`la_clr`) and bit 7 (`sm_rst`) are strobes. A write that sets them drives them high for exactly one cycle, and they then read back as 0.
- R9: The outputs map as follows. `pin_oe` is register 0 bits PINS-1:0 and `pin_od` is register 1 bits PINS-1:0, with 1 meaning enabled. `pullup_en` is register 2 bit 0. `mem_cs` is register 3 bits 9:8. `adc_cal` is register 10 bit 0. `periph_cfg` is registers 12 to 15, with register 12 in bits 15:0. `cfg_all` holds register i in bits 16i+15:16i.
- R10: Every bit other than the two strobes keeps its written value until that register is written again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input word present this cycle |
| in_is_cmd | input | 1 | 1: word is a command, 0: data |
| in_word | input | DW | Command (opcode in 7:0) or data word |
| rd_valid | output | 1 | Read-back word valid |
| rd_word | output | DW | Read-back register contents |
| pin_oe | output | PINS | Per-pin output enable |
| pin_od | output | PINS | Per-pin open-drain select |
| pullup_en | output | 1 | Pull-up enable |
| la_cfg | output | DW | Analyzer control word (register 3) |
| la_clr | output | 1 | One-cycle analyzer sample-counter clear |
| sm_rst | output | 1 | One-cycle command state machine reset |
| mem_cs | output | 2 | Analyzer memory chip selects |
| adc_cal | output | 1 | Calibration request for the next ADC read |
| periph_cfg | output | 4*DW | Peripheral configuration words 12..15 |
| cfg_all | output | 16*DW | Every register word, flattened |

## Verification
A written value shows on the outputs in the cycle after the edge that samples its data word. A read burst's first word follows one cycle later still, at the second edge after the count word. The bench drives every word on a falling edge and reads the outputs on falling edges, so it checks each result in exactly the cycle when it is due. It also checks the cycle before and the cycle after the first read word, to pin the latency. Strobes are sampled in the cycle just after their write and again one cycle later, to show they are exactly one cycle long. Ignored words are checked through the named outputs and later read-backs.

// File: rtl/cfgb_pkg.sv
// Package: shared constants and types for the stream-addressed register bank.
// Assumes 16-bit words and a 4-bit register pointer by default.
package cfgb_pkg;
    localparam int DW_DEF = 16;
    localparam int AW_DEF = 4;

    // Command opcodes carried in bits 7:0 of a command word.
    localparam logic [7:0] OP_SETPTR = 8'h0B;
    localparam logic [7:0] OP_WRITE  = 8'h0C;
    localparam logic [7:0] OP_READ   = 8'h0D;

    // Register indices that feed named outputs.
    localparam int IDX_OE   = 0;
    localparam int IDX_OD   = 1;
    localparam int IDX_HW   = 2;
    localparam int IDX_LA   = 3;
    localparam int IDX_ADC  = 10;
    localparam int IDX_PER  = 12;
    localparam int NPER     = 4;

    // Strobe bit positions inside the analyzer register.
    localparam int BIT_LACLR = 3;
    localparam int BIT_SMRST = 7;

    // Meaning of data words under the current command.
    typedef enum logic [1:0] {
        M_IDLE  = 2'd0,
        M_PTR   = 2'd1,
        M_WR    = 2'd2,
        M_RDN   = 2'd3
    } mode_e;
endpackage

// File: rtl/cfgb_seq.sv
// Module: command sequencer. Tracks the current command mode, owns the
// register pointer and the read-burst counter, and issues write and
// read strobes. Assumes one input word per cycle at most; words are
// dropped while a burst is in progress.
module cfgb_seq
    import cfgb_pkg::*;
#(
    parameter int AW = AW_DEF,
    parameter int DW = DW_DEF,
    parameter int CW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          in_is_cmd,
    input  logic [DW-1:0] in_word,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic          rd_en,
    output logic [AW-1:0] rd_addr,
    output logic          busy,
    output logic [AW-1:0] ptr_o
);
    localparam logic [AW-1:0] PTR_ONE = AW'(1);
    localparam logic [CW-1:0] CNT_ONE = CW'(1);

    mode_e         mode;
    logic [AW-1:0] ptr;
    logic [CW-1:0] remain;
    logic          accept;

    // Decode acceptance and the strobes for this cycle.
    always_comb begin
        busy    = (remain != '0);
        accept  = in_valid && !busy;
        wr_en   = accept && !in_is_cmd && (mode == M_WR);
        wr_addr = ptr;
        wr_data = in_word;
        rd_en   = busy;
        rd_addr = ptr;
        ptr_o   = ptr;
    end

    // Update mode, pointer and burst counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode   <= M_IDLE;
            ptr    <= '0;
            remain <= '0;
        end else if (busy) begin
            ptr    <= ptr + PTR_ONE;
            remain <= remain - CNT_ONE;
        end else if (accept) begin
            if (in_is_cmd) begin
                case (in_word[7:0])
                    OP_SETPTR: mode <= M_PTR;
                    OP_WRITE:  mode <= M_WR;
                    OP_READ:   mode <= M_RDN;
                    default:   mode <= M_IDLE;
                endcase
            end else begin
                case (mode)
                    M_PTR:   ptr    <= in_word[AW-1:0];
                    M_WR:    ptr    <= ptr + PTR_ONE;
                    M_RDN:   remain <= in_word[CW-1:0];
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/cfgb_regs.sv
// Module: register storage. One word per register, built by a generate
// loop. The register picked by PULSE_REG clears its PULSE_MASK bits one
// cycle after they are written. Read data is combinational from rd_addr.
module cfgb_regs
    import cfgb_pkg::*;
#(
    parameter int            AW         = AW_DEF,
    parameter int            DW         = DW_DEF,
    parameter int            PULSE_REG  = IDX_LA,
    parameter logic [DW-1:0] PULSE_MASK = DW'((1 << BIT_LACLR) | (1 << BIT_SMRST))
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [AW-1:0]           wr_addr,
    input  logic [DW-1:0]           wr_data,
    input  logic [AW-1:0]           rd_addr,
    output logic [DW-1:0]           rd_data,
    output logic [(1<<AW)*DW-1:0]   flat
);
    localparam int NREG = 1 << AW;

    logic [DW-1:0] q [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        localparam logic [AW-1:0] IDX = AW'(i);
        localparam logic [DW-1:0] CLR = (i == PULSE_REG) ? PULSE_MASK : '0;

        // Store a write to this register, otherwise drop its strobe bits.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q[i] <= '0;
            end else if (wr_en && (wr_addr == IDX)) begin
                q[i] <= wr_data;
            end else begin
                q[i] <= q[i] & ~CLR;
            end
        end

        assign flat[i*DW +: DW] = q[i];
    end

    // Select the word addressed by the read pointer.
    always_comb rd_data = q[rd_addr];
endmodule

// File: rtl/cfgb_rdout.sv
// Module: read-back output stage. Registers the selected word and its
// valid flag so the FIFO interface is driven straight from flops.
module cfgb_rdout
    import cfgb_pkg::*;
#(
    parameter int DW = DW_DEF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_en,
    input  logic [DW-1:0] rd_data,
    output logic          rd_valid,
    output logic [DW-1:0] rd_word
);
    // Capture one word per cycle while a burst is active.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_word  <= '0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) rd_word <= rd_data;
        end
    end
endmodule

// File: rtl/cfgb_bank.sv
// Module: top of the stream-addressed configuration register bank.
// Ties the sequencer, storage and read-back stage together and fans
// the stored words out to named configuration outputs. Assumes AW >= 4
// so that every named register index exists.
module cfgb_bank
    import cfgb_pkg::*;
#(
    parameter int PINS = 8,
    parameter int AW   = AW_DEF,
    parameter int DW   = DW_DEF
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic                  in_is_cmd,
    input  logic [DW-1:0]         in_word,
    output logic                  rd_valid,
    output logic [DW-1:0]         rd_word,
    output logic [PINS-1:0]       pin_oe,
    output logic [PINS-1:0]       pin_od,
    output logic                  pullup_en,
    output logic [DW-1:0]         la_cfg,
    output logic                  la_clr,
    output logic                  sm_rst,
    output logic [1:0]            mem_cs,
    output logic                  adc_cal,
    output logic [NPER*DW-1:0]    periph_cfg,
    output logic [(1<<AW)*DW-1:0] cfg_all
);
    localparam int NREG = 1 << AW;
    localparam int CW   = AW + 1;

    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data;
    logic          rd_en;
    logic [AW-1:0] rd_addr;
    logic [DW-1:0] rd_data;
    logic          busy;
    logic [AW-1:0] ptr;
    logic [NREG*DW-1:0] flat;

    cfgb_seq #(.AW(AW), .DW(DW), .CW(CW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_is_cmd (in_is_cmd),
        .in_word   (in_word),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .busy      (busy),
        .ptr_o     (ptr)
    );

    cfgb_regs #(.AW(AW), .DW(DW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .flat    (flat)
    );

    cfgb_rdout #(.DW(DW)) u_rdout (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (rd_en),
        .rd_data  (rd_data),
        .rd_valid (rd_valid),
        .rd_word  (rd_word)
    );

    // Fan stored words out to the named configuration outputs.
    always_comb begin
        cfg_all    = flat;
        pin_oe     = flat[IDX_OE*DW +: PINS];
        pin_od     = flat[IDX_OD*DW +: PINS];
        pullup_en  = flat[IDX_HW*DW];
        la_cfg     = flat[IDX_LA*DW +: DW];
        la_clr     = flat[IDX_LA*DW + BIT_LACLR];
        sm_rst     = flat[IDX_LA*DW + BIT_SMRST];
        mem_cs     = flat[IDX_LA*DW + 8 +: 2];
        adc_cal    = flat[IDX_ADC*DW];
        periph_cfg = flat[IDX_PER*DW +: NPER*DW];
    end
endmodule

// File: rtl/cfgb_chk.sv
// Module: property checker for cfgb_bank, attached by bind. Observes the
// sequencer strobes, the pointer and the outputs.
module cfgb_chk #(
    parameter int AW   = 4,
    parameter int DW   = 16,
    parameter int PINS = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            wr_en,
    input logic [AW-1:0]   wr_addr,
    input logic [DW-1:0]   wr_data,
    input logic            busy,
    input logic [AW-1:0]   ptr,
    input logic            rd_valid,
    input logic            la_clr,
    input logic            sm_rst,
    input logic [PINS-1:0] pin_oe
);
    localparam logic [AW-1:0] LA_IDX = AW'(3);
    localparam logic [AW-1:0] ONE    = AW'(1);

    a_r4_ptr_advance: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ptr == $past(wr_addr) + ONE);

    a_r5_valid_follows_burst: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(busy));

    a_r7_no_write_in_burst: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !wr_en);

    a_r8_clr_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        la_clr && !(wr_en && wr_addr == LA_IDX && wr_data[3]) |=> !la_clr);

    a_r8_smrst_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        sm_rst && !(wr_en && wr_addr == LA_IDX && wr_data[7]) |=> !sm_rst);

    a_r10_oe_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(pin_oe));
endmodule

bind cfgb_bank cfgb_chk #(.AW(AW), .DW(DW), .PINS(PINS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .busy     (busy),
    .ptr      (ptr),
    .rd_valid (rd_valid),
    .la_clr   (la_clr),
    .sm_rst   (sm_rst),
    .pin_oe   (pin_oe)
);

// File: tb/test_cfgb_bank.sv
// Bench: loads the bank from a vector table, reads it back, then runs
// directed tests for latency, wrap, zero count, strobes and ignored input.
module test_cfgb_bank;
    localparam logic [7:0] OP_SETPTR = 8'h0B;
    localparam logic [7:0] OP_WRITE  = 8'h0C;
    localparam logic [7:0] OP_READ   = 8'h0D;
    localparam logic [15:0] VEC [16] = '{
        16'h003C, 16'h0081, 16'h0001, 16'h0321, 16'h4444, 16'h5A5A, 16'h6006, 16'h7777,
        16'h8118, 16'h9999, 16'h0001, 16'hBEEF, 16'hC0DE, 16'hD00D, 16'hE1E1, 16'hF00F};

    logic        clk, rst_n, in_valid, in_is_cmd;
    logic [15:0] in_word;
    logic        rd_valid;
    logic [15:0] rd_word;
    logic [7:0]  pin_oe, pin_od;
    logic        pullup_en, la_clr, sm_rst, adc_cal;
    logic [15:0] la_cfg;
    logic [1:0]  mem_cs;
    logic [63:0] periph_cfg;
    logic [255:0] cfg_all;

    int nchk = 0;
    int nfail = 0;
    int ncap = 0;
    logic [15:0] cap [32];

    cfgb_bank i_cfgb_bank (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_is_cmd(in_is_cmd),
        .in_word(in_word), .rd_valid(rd_valid), .rd_word(rd_word),
        .pin_oe(pin_oe), .pin_od(pin_od), .pullup_en(pullup_en), .la_cfg(la_cfg),
        .la_clr(la_clr), .sm_rst(sm_rst), .mem_cs(mem_cs), .adc_cal(adc_cal),
        .periph_cfg(periph_cfg), .cfg_all(cfg_all));

    initial clk = 1'b0;
    always #4 clk = ~clk;

    // Record every read-back word away from the active edge.
    always @(negedge clk) begin
        if (rd_valid && ncap < 32) begin
            cap[ncap] = rd_word;
            ncap = ncap + 1;
        end
    end

    task automatic check(input logic ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic put(input logic c, input logic [15:0] w);
        in_valid = 1'b1; in_is_cmd = c; in_word = w;
        @(negedge clk);
        in_valid = 1'b0; in_is_cmd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_is_cmd = 1'b0; in_word = '0;
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1: reset state
        check(cfg_all == '0, "R1 all regs zero", cfg_all[63:0], 64'h0);
        check(rd_valid == 1'b0, "R1 rd_valid low", 64'(rd_valid), 64'h0);
        // R1/R4: write without pointer set lands in register 0
        put(1, 16'(OP_WRITE)); put(0, 16'h00A5);
        check(pin_oe == 8'hA5, "R1 R4 first write to reg0", 64'(pin_oe), 64'hA5);

        // R4 vector table: set pointer 0, load all 16 with one command
        put(1, 16'(OP_SETPTR)); put(0, 16'h0000);
        put(1, 16'(OP_WRITE));
        for (int i = 0; i < 16; i++) put(0, VEC[i]);
        // R9: named outputs
        check(pin_oe == 8'h3C && pin_od == 8'h81, "R9 oe/od", {pin_oe, pin_od}, 64'h3C81);
        check(pullup_en && adc_cal && mem_cs == 2'd3, "R9 pullup/adc/cs",
              {pullup_en, adc_cal, mem_cs}, 64'hF);
        check(periph_cfg == 64'hF00F_E1E1_D00D_C0DE, "R9 periph_cfg", periph_cfg,
              64'hF00F_E1E1_D00D_C0DE);
        // R5/R4: pointer wrapped to 0; read all 16 back
        ncap = 0;
        put(1, 16'(OP_READ)); put(0, 16'd16);
        idle(20);
        check(ncap == 16, "R5 burst length 16", 64'(ncap), 64'd16);
        for (int i = 0; i < 16; i++)
            check(cap[i] == VEC[i], "R5 R4 readback vector", 64'(cap[i]), 64'(VEC[i]));

        // R5 latency: first word due after the second edge past the count word
        put(1, 16'(OP_SETPTR)); put(0, 16'h0002);
        put(1, 16'(OP_READ)); ncap = 0;
        put(0, 16'h0001);
        check(rd_valid == 1'b0, "R5 not valid after first edge", 64'(rd_valid), 64'h0);
        idle(1);
        check(rd_valid && rd_word == VEC[2], "R5 word after second edge",
              64'(rd_word), 64'(VEC[2]));
        idle(1);
        check(rd_valid == 1'b0, "R5 single word only", 64'(rd_valid), 64'h0);

        // R6: zero count sends nothing, pointer stays
        put(1, 16'(OP_SETPTR)); put(0, 16'h0005);
        put(1, 16'(OP_READ)); ncap = 0;
        put(0, 16'h0000); idle(4);
        check(ncap == 0, "R6 zero count no words", 64'(ncap), 64'h0);
        put(0, 16'h0001); idle(4);
        check(ncap == 1 && cap[0] == VEC[5], "R6 pointer unchanged", 64'(cap[0]), 64'(VEC[5]));

        // R5: wrap on read and pointer after burst
        put(1, 16'(OP_SETPTR)); put(0, 16'h000E);
        put(1, 16'(OP_READ)); ncap = 0;
        put(0, 16'h0003); idle(6);
        check(ncap == 3 && cap[0] == VEC[14] && cap[1] == VEC[15] && cap[2] == VEC[0],
              "R5 read wrap", {cap[0], cap[1], cap[2]}, {VEC[14], VEC[15], VEC[0]});
        put(0, 16'h0001); idle(4);
        check(ncap == 4 && cap[3] == VEC[1], "R5 pointer after burst", 64'(cap[3]), 64'(VEC[1]));

        // R3: only bits 3:0 of the pointer word count
        put(1, 16'(OP_SETPTR)); put(0, 16'hFFF2);
        put(1, 16'(OP_WRITE)); put(0, 16'h0000);
        check(pullup_en == 1'b0 && pin_od == 8'h81, "R3 pointer low bits",
              {pullup_en, pin_od}, 64'h081);

        // R8: strobes last one cycle, chip selects hold (R10)
        put(1, 16'(OP_SETPTR)); put(0, 16'h0003);
        put(1, 16'(OP_WRITE)); put(0, 16'h0388);
        check(la_clr && sm_rst && mem_cs == 2'd3, "R8 strobes high",
              {la_clr, sm_rst, mem_cs}, 64'hF);
        idle(1);
        check(!la_clr && !sm_rst && mem_cs == 2'd3, "R8 R10 strobes cleared, cs held",
              {la_clr, sm_rst, mem_cs}, 64'h3);
        put(1, 16'(OP_SETPTR)); put(0, 16'h0003);
        put(1, 16'(OP_READ)); ncap = 0;
        put(0, 16'h0001); idle(4);
        check(ncap == 1 && cap[0] == 16'h0300, "R8 strobes read back zero",
              64'(cap[0]), 64'h0300);

        // R7: words during a burst are dropped
        put(1, 16'(OP_SETPTR)); put(0, 16'h0000);
        put(1, 16'(OP_READ)); ncap = 0;
        put(0, 16'h0004);
        put(1, 16'(OP_WRITE)); put(0, 16'hFFFF);
        idle(6);
        check(ncap == 4 && cap[3] == 16'h0300, "R7 burst unaffected", 64'(ncap), 64'd4);
        check(pin_oe == 8'h3C && pin_od == 8'h81 && !pullup_en, "R7 no write in burst",
              {pin_oe, pin_od}, 64'h3C81);
        put(0, 16'h0001); idle(4);
        check(ncap == 5 && cap[4] == VEC[4], "R7 mode kept as read", 64'(cap[4]), 64'(VEC[4]));

        // R2: unknown opcode makes data words inert
        ncap = 0;
        put(1, 16'h0005); put(0, 16'hFFFF); put(0, 16'h1234);
        idle(4);
        check(ncap == 0 && pin_oe == 8'h3C && la_cfg == 16'h0300,
              "R2 other opcode ignored", {pin_oe, la_cfg}, 64'h3C0300);
        check(periph_cfg == 64'hF00F_E1E1_D00D_C0DE && adc_cal, "R2 R10 held values",
              periph_cfg, 64'hF00F_E1E1_D00D_C0DE);

        finish_run();
    end
endmodule